// File: doc/BRIEF.md
# Processor Tick Timer

This block is a processor tick timer. It holds two registers. The control register carries a 28-bit match period, an interrupt enable, a sticky pending flag and a 2-bit operating mode. The count register is a 32-bit up-counter. Software reaches both registers through a one-bit register select with a write strobe and a combinational read bus. The counter advances on each clock where the tick enable is high while the timer is running. A tick on which the low 28 count bits equal the period sets the pending flag. Whether the counter then wraps to zero, halts or keeps counting depends on the mode.

The interrupt line is the pending flag gated by the enable. Software acknowledges a timer event by rewriting the control register with the pending bit at zero. A pending bit written as one leaves the stored flag as it was, so a read-modify-write does not clear an event by accident. The running state changes only when a write actually changes the mode field. A one-shot timer that has stopped therefore stays stopped when the same one-shot mode is written again.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register reads 0 (mode off, pending clear, enable clear, period 0), the count reads 0 and `irq` is low.
- R2: Control register layout: period in bits 27:0, pending in bit 28, interrupt enable in bit 29, mode in bits 31:30 with 00 off, 01 restart, 10 one-shot, 11 continuous. The period, enable and mode bits read back as written. The pending bit reads the stored flag.
- R3: While running, the count rises by one on every clock with `clk_en` high and holds on clocks with `clk_en` low.
- R4: A control write that changes the mode to off stops counting. One that changes it to any other mode starts counting. A write with an unchanged mode leaves the running state as it was.
- R5: A running tick with count[27:0] equal to the period sets the pending flag. Count bits 31:28 take no part in the comparison.
- R6: In restart mode the count becomes 0 on the matching tick.
- R7: In one-shot mode the matching tick stops counting, and the count stays at the period.
- R8: In continuous mode counting continues past the match.
- R9: A control write with bit 28 at 1 keeps the stored pending flag, so it neither sets nor clears it. A write with bit 28 at 0 clears it.
- R10: A count-register write loads the count and takes precedence over the increment in that cycle. A count read returns the current count.
- R11: `irq` is high exactly when the pending flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Tick enable; the counter advances only when high |
| reg_sel | input | 1 | Register select: 0 control, 1 count |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Timer interrupt request |

## Verification
The assertions assume a register write lasts exactly one clock and that the select is stable while the strobe is high. The bench changes every input only at falling edges and drops the strobe after one cycle. The match and stop properties assume the hit is evaluated on the period held before any same-cycle control write. The bench therefore never rewrites the control register on the tick where a match is due. Reads are taken between edges, with the select changed and the bus sampled inside one half period.

// File: rtl/tt_pkg.sv
// Shared definitions for the tick timer: mode encoding and control field positions.
// Assumes a 32-bit register bus, with the period taking all bits below the flags.
package tt_pkg;
    typedef enum logic [1:0] {
        TM_OFF     = 2'b00,
        TM_RESTART = 2'b01,
        TM_ONESHOT = 2'b10,
        TM_FREE    = 2'b11
    } tmode_e;
endpackage

// File: rtl/tt_ctrl_reg.sv
// Control register: holds period, interrupt enable, sticky pending flag and mode.
// Assumes wr is a single-cycle strobe. The hit from the counter is registered into pending.
module tt_ctrl_reg
    import tt_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PER_W = DATA_W - 4,
    localparam int PEND_B = PER_W,
    localparam int IE_B = PER_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hit,
    output logic [PER_W-1:0]  period,
    output logic              ie,
    output logic              pend,
    output tmode_e            mode
);
    // Register update: software write, with pending kept or cleared, or the hit setting pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            ie     <= 1'b0;
            pend   <= 1'b0;
            mode   <= TM_OFF;
        end else if (wr) begin
            period <= wr_data[PER_W-1:0];
            ie     <= wr_data[IE_B];
            mode   <= tmode_e'(wr_data[DATA_W-1:DATA_W-2]);
            pend   <= wr_data[PEND_B] ? (pend | hit) : 1'b0;
        end else begin
            pend   <= pend | hit;
        end
    end

    assert_clear_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !wr_data[PEND_B] |=> !pend);
    assert_keep_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr && wr_data[PEND_B] && pend |=> pend);
    assert_hit_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !wr |=> pend);
endmodule

// File: rtl/tt_counter.sv
// Count register and run flag. Detects a match of the low period bits on a running tick.
// Assumes mode_cur is the stored mode and mode_new the value a same-cycle control write carries.
module tt_counter
    import tt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             mode_wr,
    input  tmode_e           mode_new,
    input  tmode_e           mode_cur,
    input  logic [PER_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             hit
);
    logic mode_change;
    logic stop_now;
    logic wrap_now;

    // Match detection and the actions the current mode takes on it.
    always_comb begin
        hit         = run && tick && (cnt[PER_W-1:0] == period);
        mode_change = mode_wr && (mode_new != mode_cur);
        stop_now    = hit && (mode_cur == TM_ONESHOT);
        wrap_now    = hit && (mode_cur == TM_RESTART);
    end

    // Run flag: follows an actual mode change, and one-shot clears it on the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (mode_change) begin
            run <= (mode_new != TM_OFF);
        end else if (stop_now) begin
            run <= 1'b0;
        end
    end

    // Counter: a load wins, then a restart wrap, then the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (wrap_now) begin
            cnt <= '0;
        end else if (run && tick && !stop_now) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !ld |=> $stable(cnt));
    assert_oneshot_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_now && !mode_change |=> !run);
    assert_stop_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(mode_wr) || $past(hit));
    assert_restart_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_now && !ld |=> cnt == '0);
endmodule

// File: rtl/tick_timer.sv
// Tick timer top: register port decode, read mux and interrupt gating.
// Assumes wr_en is a one-cycle strobe and reg_sel is stable while it is high.
module tick_timer
    import tt_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PER_W = DATA_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic             ctl_wr;
    logic             cnt_wr;
    logic [PER_W-1:0] period;
    logic             ie;
    logic             pend;
    tmode_e           mode;
    logic [DATA_W-1:0] cnt;
    logic             run;
    logic             hit;

    // Write decode for the two registers.
    always_comb begin
        ctl_wr = wr_en && !reg_sel;
        cnt_wr = wr_en && reg_sel;
    end

    tt_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wr_data(wr_data), .hit(hit),
        .period(period), .ie(ie), .pend(pend), .mode(mode)
    );

    tt_counter #(.CNT_W(DATA_W), .PER_W(PER_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(clk_en), .ld(cnt_wr), .ld_val(wr_data),
        .mode_wr(ctl_wr), .mode_new(tmode_e'(wr_data[DATA_W-1:DATA_W-2])),
        .mode_cur(mode), .period(period), .cnt(cnt), .run(run), .hit(hit)
    );

    // Read mux and interrupt output.
    always_comb begin
        rd_data = reg_sel ? cnt : {mode, ie, pend, period};
        irq     = pend && ie;
    end

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie && pend);
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(wr_data));
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/100ps
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    tick_timer u_tick_timer (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic [1:0] m, input logic e,
                                       input logic p, input logic [27:0] per);
        return {m, e, p, per};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic s, output logic [31:0] v);
        reg_sel = s;
        #0.4;
        v = rd_data;
    endtask

    task automatic wr(input logic s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input logic [27:0] target);
        logic [31:0] v;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rd(1'b1, v);
            if (v[27:0] == target) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R1 ctrl", v, 32'h0);
        rd(1'b1, v); chk("R1 count", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        clk_en = 1'b1;
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R4 off mode holds", v, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        wr(1'b0, mk(2'b00, 1'b1, 1'b1, 28'h123_4567));
        rd(1'b0, v); chk("R2 R9 layout, keep does not set", v, 32'h2123_4567);
        wr(1'b1, 32'hDEAD_BEEF);
        rd(1'b1, v); chk("R10 load", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_continuous();
        logic [31:0] v;
        wr(1'b1, 32'hF000_0000);
        wr(1'b0, mk(2'b11, 1'b1, 1'b0, 28'd10));
        rd(1'b1, v); chk("R4 start value", v, 32'hF000_0000);
        @(negedge clk);
        rd(1'b1, v); chk("R3 increment", v, 32'hF000_0001);
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R3 hold", v, 32'hF000_0001);
        clk_en = 1'b1;
        wait_cnt(28'd10);
        rd(1'b0, v); chk("R5 no pending before match", {31'b0, v[28]}, 32'h0);
        @(negedge clk);
        rd(1'b1, v); chk("R8 continues", v, 32'hF000_000B);
        rd(1'b0, v); chk("R5 pending on match", {31'b0, v[28]}, 32'h1);
        chk("R11 irq set", {31'b0, irq}, 32'h1);
        wr(1'b0, mk(2'b11, 1'b0, 1'b1, 28'd10));
        rd(1'b0, v); chk("R9 keep", {31'b0, v[28]}, 32'h1);
        chk("R11 masked", {31'b0, irq}, 32'h0);
        wr(1'b0, mk(2'b11, 1'b1, 1'b1, 28'd10));
        chk("R11 unmasked", {31'b0, irq}, 32'h1);
        wr(1'b0, mk(2'b11, 1'b1, 1'b0, 28'd10));
        rd(1'b0, v); chk("R9 clear", {31'b0, v[28]}, 32'h0);
        chk("R11 cleared", {31'b0, irq}, 32'h0);
        wr(1'b1, 32'd100);
        rd(1'b1, v); chk("R10 load wins", v, 32'd100);
        @(negedge clk);
        rd(1'b1, v); chk("R4 same mode keeps running", v, 32'd101);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(1'b0, mk(2'b00, 1'b0, 1'b0, 28'd0));
        wr(1'b1, 32'd0);
        repeat (2) @(negedge clk);
        rd(1'b1, v); chk("R4 stopped", v, 32'd0);
        wr(1'b0, mk(2'b01, 1'b1, 1'b0, 28'd3));
        wait_cnt(28'd3);
        @(negedge clk);
        rd(1'b1, v); chk("R6 wrap", v, 32'd0);
        rd(1'b0, v); chk("R6 pending", {31'b0, v[28]}, 32'h1);
        @(negedge clk);
        rd(1'b1, v); chk("R6 resumes", v, 32'd1);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(1'b0, mk(2'b00, 1'b1, 1'b0, 28'd0));
        wr(1'b1, 32'd0);
        wr(1'b0, mk(2'b10, 1'b1, 1'b0, 28'd4));
        wait_cnt(28'd4);
        @(negedge clk);
        rd(1'b1, v); chk("R7 held at period", v, 32'd4);
        rd(1'b0, v); chk("R7 pending", {31'b0, v[28]}, 32'h1);
        repeat (5) @(negedge clk);
        rd(1'b1, v); chk("R7 stays stopped", v, 32'd4);
        wr(1'b0, mk(2'b10, 1'b1, 1'b0, 28'd4));
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R4 same mode no restart", v, 32'd4);
        wr(1'b0, mk(2'b11, 1'b1, 1'b0, 28'd4));
        @(negedge clk);
        rd(1'b1, v); chk("R4 mode change restarts", v, 32'd5);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_layout();
                t_continuous();
                t_restart();
                t_oneshot();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule